// File: doc/BRIEF.md
# Field Bus Request Frame Decoder

This block sits behind the demodulator of a two-wire field bus slave. It takes bits that are already recovered, each one marked by a single-cycle strobe. From them it builds 14-bit master requests and checks the framing and the even parity. It then compares the address field with the slave address held on its static inputs. When the extended mode input is set, information bit I3 becomes a sixth address bit that picks the A or B slave at that address. A stored address of zero means no regular address has been assigned, so addressed requests never match it.

An accepted request raises a one-cycle flag: a data call, a parameter call or a command call. The five information bits are held on an output for the logic behind the slave. Two command forms also raise a soft-reset request: a reset addressed to this slave, and a reset broadcast to address zero. Every addressed request is answered at once with a 7-bit reply, built from a 4-bit reply value that the logic behind the slave supplies. Each reply bit is held for `BIT_CLKS` clocks, which is 32 clocks at a 5.333333 MHz clock.

The controller is a three-state machine:
- **IDLE** waits for a strobed 0 bit, which is a start bit, and moves to **RECV**. A strobed 1 bit leaves it in **IDLE**.
- **RECV** collects the remaining 13 bits. On the 14th bit it moves to **REPLY** if the frame was accepted and addressed to this slave. Otherwise it goes back to **IDLE**.
- **REPLY** lasts while the serializer drives the reply. It returns to **IDLE** at the end of the last bit slot.

Top module: `req_frame_decoder`

## Requirements
- R1: After reset the flags and `soft_reset` are 0, `req_info` is 0, `tx_active` is 0 and `tx_bit` is 1.
- R2: A frame starts with a strobed 0 bit while idle. Strobed 1 bits while idle are ignored. The 14 bits arrive first-to-last as: start, control bit, A4..A0, I4..I0, parity, end.
- R3: A frame is discarded silently, with no flag, no `req_info` change and no reply, unless two conditions hold. The count of ones over the control, address, information and parity bits must be even. The end bit must be 1.
- R4: When extended mode is off, a frame addresses this slave when A4..A0 equals `my_addr`. I3 is not compared.
- R5: When extended mode is on, I3 must also equal `my_sel` (0 selects the A slave, 1 the B slave).
- R6: When `my_addr` is zero, no addressed request is accepted.
- R7: An addressed frame with control bit 0 pulses `data_call` for one cycle if I4 = 0, or `param_call` if I4 = 1. The pulse comes in the cycle after the clock edge that samples the end bit.
- R8: An addressed frame with control bit 1 pulses `cmd_call` in that same cycle.
- R9: From the flag cycle on, `req_info` holds I4..I0 of the last accepted frame, I4 in bit 4.
- R10: `soft_reset` pulses with `cmd_call` when the addressed command has I4,I2,I1,I0 = 1,1,0,0 (I3 ignored). It also pulses, without `cmd_call` and without a reply, for a control-1 frame to address 00000 with I4..I0 = 10101, whatever the stored address.
- R11: An addressed frame starts the reply in the flag cycle. `tx_active` is then high for 7·`BIT_CLKS` cycles and sends these bits, each for `BIT_CLKS` cycles: 0, `resp_info`[3..0] (bit 3 first), even parity of those four bits, 1. When idle, `tx_bit` is 1.
- R12: Bits strobed while a reply is being sent are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Strobe marking a received bit |
| rx_bit | input | 1 | Received bit value |
| my_addr | input | 5 | Stored slave address |
| my_sel | input | 1 | Stored A/B select bit |
| ext_mode | input | 1 | Extended address mode enable |
| resp_info | input | 4 | Reply information bits, sampled on acceptance |
| data_call | output | 1 | Data call pulse |
| param_call | output | 1 | Parameter call pulse |
| cmd_call | output | 1 | Command call pulse |
| soft_reset | output | 1 | Soft-reset request pulse |
| req_info | output | 5 | Information bits of the last accepted frame |
| tx_bit | output | 1 | Reply serial bit |
| tx_active | output | 1 | Reply in progress |

## Verification
Some rules are checked by assertions on every cycle:
- At most one call flag is high at a time, and each flag lasts a single cycle.
- A flag always comes with an active reply that opens with a 0 bit and closes with a 1 bit.
- A broadcast reset never starts a reply.
- A zero address never yields a flag.
- A reply is never followed directly by reception.

Other behaviour only the bench scenarios can show:
- That bad parity, a zero end bit, a wrong address or a wrong select leave every output untouched.
- That the I3 comparison really follows the mode input.
- That the reply carries the exact `resp_info` bits and their parity.
- That a complete valid frame sent during a reply is dropped.

// File: rtl/frame_pkg.sv
package frame_pkg;
    localparam int REQ_BITS   = 14;
    localparam int RSP_BITS   = 7;
    localparam int ADDR_W     = 5;
    localparam int INFO_W     = 5;
    localparam int RSP_INFO_W = 4;
    localparam int CNT_W      = $clog2(REQ_BITS);

    localparam logic [ADDR_W-1:0] BCAST_ADDR       = '0;
    localparam logic [INFO_W-1:0] BCAST_RESET_INFO = 5'b10101;
    // compared against {I4, I2, I1, I0}; I3 is left out
    localparam logic [3:0]        SLAVE_RESET_KEY  = 4'b1100;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_REPLY
    } dec_state_t;

    typedef struct packed {
        logic ok;
        logic data;
        logic param;
        logic cmd;
        logic rst_req;
        logic reply;
    } decode_t;
endpackage

// File: rtl/req_shifter.sv
module req_shifter #(
    parameter int W = frame_pkg::REQ_BITS - 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] sh
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (load) begin
            sh <= {{(W-1){1'b0}}, bit_in};
        end else if (shift) begin
            sh <= {sh[W-2:0], bit_in};
        end
    end
endmodule

// File: rtl/req_decode.sv
module req_decode
    import frame_pkg::*;
(
    input  logic [REQ_BITS-1:0] frame,
    input  logic [ADDR_W-1:0]   my_addr,
    input  logic                my_sel,
    input  logic                ext_mode,
    output decode_t             dec
);
    logic              ctl;
    logic [ADDR_W-1:0] addr;
    logic [INFO_W-1:0] info;
    logic              sel_ok;
    logic              hit;
    logic              bcast;

    assign ctl  = frame[12];
    assign addr = frame[11:7];
    assign info = frame[6:2];

    always_comb begin
        dec.ok    = !frame[REQ_BITS-1] && frame[0] && !(^frame[REQ_BITS-2:1]);
        sel_ok    = !ext_mode || (info[3] == my_sel);
        hit       = dec.ok && (my_addr != '0) && (addr == my_addr) && sel_ok;
        bcast     = dec.ok && ctl && (addr == BCAST_ADDR) && (info == BCAST_RESET_INFO);
        dec.data  = hit && !ctl && !info[4];
        dec.param = hit && !ctl && info[4];
        dec.cmd   = hit && ctl;
        dec.rst_req = bcast ||
                      (dec.cmd && ({info[4], info[2:0]} == SLAVE_RESET_KEY));
        dec.reply = hit;
    end
endmodule

// File: rtl/reply_ser.sv
module reply_ser
    import frame_pkg::*;
#(
    parameter int BIT_CLKS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [RSP_INFO_W-1:0] info,
    output logic                  tx_bit,
    output logic                  busy,
    output logic                  last
);
    localparam int CW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam int BW = $clog2(RSP_BITS);

    logic [RSP_BITS-1:0] word;
    logic [CW-1:0]       cnt;
    logic [BW-1:0]       bitn;
    logic                slot_end;

    assign slot_end = (cnt == CW'(BIT_CLKS - 1));
    assign last     = busy && slot_end && (bitn == BW'(RSP_BITS - 1));
    assign tx_bit   = busy ? word[RSP_BITS-1] : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '1;
            cnt  <= '0;
            bitn <= '0;
            busy <= 1'b0;
        end else if (start) begin
            word <= {1'b0, info, ^info, 1'b1};
            cnt  <= '0;
            bitn <= '0;
            busy <= 1'b1;
        end else if (busy) begin
            if (slot_end) begin
                cnt <= '0;
                if (last) begin
                    busy <= 1'b0;
                end else begin
                    bitn <= bitn + 1'b1;
                    word <= {word[RSP_BITS-2:0], 1'b1};
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    a_r11_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx_bit);
    a_r11_end_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tx_bit));
endmodule

// File: rtl/req_frame_decoder.sv
module req_frame_decoder
    import frame_pkg::*;
#(
    parameter int BIT_CLKS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic                  rx_bit,
    input  logic [ADDR_W-1:0]     my_addr,
    input  logic                  my_sel,
    input  logic                  ext_mode,
    input  logic [RSP_INFO_W-1:0] resp_info,
    output logic                  data_call,
    output logic                  param_call,
    output logic                  cmd_call,
    output logic                  soft_reset,
    output logic [INFO_W-1:0]     req_info,
    output logic                  tx_bit,
    output logic                  tx_active
);
    dec_state_t            state, state_nx;
    logic [CNT_W-1:0]      bit_cnt;
    logic [REQ_BITS-2:0]   sh;
    logic [REQ_BITS-1:0]   frame;
    decode_t               dec;
    logic                  start_seen, last_rx, accept, take_any, ser_last;

    assign start_seen = (state == ST_IDLE) && rx_valid && !rx_bit;
    assign last_rx    = (state == ST_RECV) && rx_valid && (bit_cnt == CNT_W'(REQ_BITS - 1));
    assign frame      = {sh, rx_bit};
    assign accept     = last_rx && dec.ok;
    assign take_any   = accept && (dec.reply || dec.rst_req);

    req_shifter #(.W(REQ_BITS - 1)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start_seen),
        .shift ((state == ST_RECV) && rx_valid),
        .bit_in(rx_bit),
        .sh    (sh)
    );

    req_decode u_dec (
        .frame   (frame),
        .my_addr (my_addr),
        .my_sel  (my_sel),
        .ext_mode(ext_mode),
        .dec     (dec)
    );

    reply_ser #(.BIT_CLKS(BIT_CLKS)) u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept && dec.reply),
        .info  (resp_info),
        .tx_bit(tx_bit),
        .busy  (tx_active),
        .last  (ser_last)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start_seen) state_nx = ST_RECV;
            ST_RECV:  if (last_rx) state_nx = (accept && dec.reply) ? ST_REPLY : ST_IDLE;
            ST_REPLY: if (ser_last) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            data_call  <= 1'b0;
            param_call <= 1'b0;
            cmd_call   <= 1'b0;
            soft_reset <= 1'b0;
            req_info   <= '0;
        end else begin
            data_call  <= accept && dec.data;
            param_call <= accept && dec.param;
            cmd_call   <= accept && dec.cmd;
            soft_reset <= accept && dec.rst_req;
            if (take_any) req_info <= frame[6:2];
            if (start_seen)                          bit_cnt <= CNT_W'(1);
            else if (last_rx)                        bit_cnt <= '0;
            else if ((state == ST_RECV) && rx_valid) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    a_r7_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_call, param_call, cmd_call}));
    a_r7_data_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        data_call |=> !data_call);
    a_r11_flag_reply: assert property (@(posedge clk) disable iff (!rst_n)
        (data_call || param_call || cmd_call) |-> tx_active);
    a_r10_bcast_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_reset && !cmd_call) |-> !tx_active);
    a_r6_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(my_addr) == '0) |-> !(data_call || param_call || cmd_call));
    a_r12_reply_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPLY) |=> (state != ST_RECV));
endmodule

// File: tb/req_frame_decoder_test.sv
module req_frame_decoder_test;
    localparam int BCLK = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0, rx_bit = 1'b1;
    logic [4:0] my_addr = 5'd5;
    logic       my_sel = 1'b0, ext_mode = 1'b0;
    logic [3:0] resp_info = 4'b1011;
    logic       data_call, param_call, cmd_call, soft_reset, tx_bit, tx_active;
    logic [4:0] req_info;

    int checks = 0, fails = 0;
    int c_data = 0, c_param = 0, c_cmd = 0, c_srst = 0, c_tx = 0;

    always #5 clk = ~clk;

    req_frame_decoder #(.BIT_CLKS(BCLK)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit),
        .my_addr(my_addr), .my_sel(my_sel), .ext_mode(ext_mode),
        .resp_info(resp_info), .data_call(data_call), .param_call(param_call),
        .cmd_call(cmd_call), .soft_reset(soft_reset), .req_info(req_info),
        .tx_bit(tx_bit), .tx_active(tx_active)
    );

    // behavioural reference model
    int q[$];
    int txq[$];
    logic e_data = 0, e_param = 0, e_cmd = 0, e_srst = 0;
    logic [4:0] e_info = 0;

    task automatic model_eval();
        int ones = 0;
        int cb, addr, info, i4, i3;
        bit ok, hit, bc;
        for (int k = 1; k <= 12; k++) ones += q[k];
        cb = q[1];
        addr = 0;
        for (int k = 2; k <= 6; k++) addr = addr * 2 + q[k];
        info = 0;
        for (int k = 7; k <= 11; k++) info = info * 2 + q[k];
        i4 = q[7];
        i3 = q[8];
        ok  = (q[0] == 0) && (q[13] == 1) && (ones % 2 == 0);
        hit = ok && (my_addr != 0) && (addr == int'(my_addr)) && (!ext_mode || i3 == int'(my_sel));
        bc  = ok && (cb == 1) && (addr == 0) && (info == 21);
        if (hit) begin
            if (cb == 0) begin
                if (i4 == 1) e_param = 1; else e_data = 1;
            end else begin
                e_cmd = 1;
                if (q[7] == 1 && q[9] == 1 && q[10] == 0 && q[11] == 0) e_srst = 1;
            end
        end
        if (bc) e_srst = 1;
        if (hit || bc) e_info = 5'(info);
        if (hit) begin
            int seq[7];
            int p = 0;
            seq[0] = 0;
            for (int k = 0; k < 4; k++) begin
                seq[k+1] = int'(resp_info[3-k]);
                p += seq[k+1];
            end
            seq[5] = p % 2;
            seq[6] = 1;
            for (int k = 0; k < 7; k++)
                for (int j = 0; j < BCLK; j++) txq.push_back(seq[k]);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); txq.delete();
            e_data = 0; e_param = 0; e_cmd = 0; e_srst = 0; e_info = 0;
        end else begin
            e_data = 0; e_param = 0; e_cmd = 0; e_srst = 0;
            if (txq.size() > 0) begin
                void'(txq.pop_front());
            end else if (rx_valid) begin
                if (q.size() == 0) begin
                    if (rx_bit == 1'b0) q.push_back(0);
                end else begin
                    q.push_back(int'(rx_bit));
                    if (q.size() == 14) begin
                        model_eval();
                        q.delete();
                    end
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            int eb, ea;
            ea = (txq.size() > 0) ? 1 : 0;
            eb = (txq.size() > 0) ? txq[0] : 1;
            chk("R7", "data_call", int'(data_call), int'(e_data));
            chk("R7", "param_call", int'(param_call), int'(e_param));
            chk("R8", "cmd_call", int'(cmd_call), int'(e_cmd));
            chk("R10", "soft_reset", int'(soft_reset), int'(e_srst));
            chk("R9", "req_info", int'(req_info), int'(e_info));
            chk("R11", "tx_active", int'(tx_active), ea);
            chk("R11", "tx_bit", int'(tx_bit), eb);
            c_data += int'(data_call); c_param += int'(param_call);
            c_cmd += int'(cmd_call); c_srst += int'(soft_reset);
            c_tx += int'(tx_active);
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic send_frame(input bit cb, input logic [4:0] a, input logic [4:0] inf,
                              input bit bad_par, input bit bad_end, input bit wait_reply);
        logic [13:0] fb;
        fb[13] = 1'b0;
        fb[12] = cb;
        fb[11:7] = a;
        fb[6:2] = inf;
        fb[1] = (^{cb, a, inf}) ^ bad_par;
        fb[0] = !bad_end;
        for (int i = 13; i >= 0; i--) begin
            rx_bit = fb[i];
            rx_valid = 1'b1;
            tick();
            rx_valid = 1'b0;
            rx_bit = 1'b1;
            tick();
            tick();
        end
        if (wait_reply) repeat (7 * BCLK + 4) tick();
    endtask

    task automatic expect_counts(input string req, input int d, input int p, input int c,
                                 input int s, input int replies);
        chk(req, "data pulses", c_data, d);
        chk(req, "param pulses", c_param, p);
        chk(req, "cmd pulses", c_cmd, c);
        chk(req, "soft_reset pulses", c_srst, s);
        chk(req, "reply cycles", c_tx, replies * 7 * BCLK);
        c_data = 0; c_param = 0; c_cmd = 0; c_srst = 0; c_tx = 0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "flags", int'({data_call, param_call, cmd_call, soft_reset}), 0);
        chk("R1", "req_info", int'(req_info), 0);
        chk("R1", "tx_active", int'(tx_active), 0);
        chk("R1", "tx_bit idle", int'(tx_bit), 1);
        tick();

        // R2: idle ones ignored, then a data call
        repeat (3) begin rx_bit = 1'b1; rx_valid = 1'b1; tick(); rx_valid = 1'b0; tick(); end
        send_frame(0, 5'd5, 5'b00110, 0, 0, 1);
        expect_counts("R2", 1, 0, 0, 0, 1);
        chk("R9", "req_info after data call", int'(req_info), 6);
        // R7 parameter call
        send_frame(0, 5'd5, 5'b10010, 0, 0, 1);
        expect_counts("R7", 0, 1, 0, 0, 1);
        // R8 command
        send_frame(1, 5'd5, 5'b00011, 0, 0, 1);
        expect_counts("R8", 0, 0, 1, 0, 1);
        // R3 parity error and bad end bit
        send_frame(0, 5'd5, 5'b00001, 1, 0, 1);
        send_frame(0, 5'd5, 5'b00001, 0, 1, 1);
        expect_counts("R3", 0, 0, 0, 0, 0);
        chk("R3", "req_info kept", int'(req_info), 3);
        // R4 wrong address, then I3 ignored in normal mode
        send_frame(0, 5'd6, 5'b00000, 0, 0, 1);
        expect_counts("R4", 0, 0, 0, 0, 0);
        resp_info = 4'b0111;
        send_frame(0, 5'd5, 5'b01000, 0, 0, 1);
        expect_counts("R4", 1, 0, 0, 0, 1);
        // R5 extended mode select
        ext_mode = 1'b1; my_sel = 1'b1;
        send_frame(0, 5'd5, 5'b00001, 0, 0, 1);
        expect_counts("R5", 0, 0, 0, 0, 0);
        send_frame(0, 5'd5, 5'b01001, 0, 0, 1);
        expect_counts("R5", 1, 0, 0, 0, 1);
        // R10 reset slave and reset broadcast
        send_frame(1, 5'd5, 5'b11100, 0, 0, 1);
        expect_counts("R10", 0, 0, 1, 1, 1);
        send_frame(1, 5'd0, 5'b10101, 0, 0, 1);
        expect_counts("R10", 0, 0, 0, 1, 0);
        chk("R10", "req_info after broadcast", int'(req_info), 21);
        // R6 zero stored address
        ext_mode = 1'b0; my_sel = 1'b0; my_addr = 5'd0;
        tick();
        send_frame(0, 5'd0, 5'b00000, 0, 0, 1);
        send_frame(1, 5'd0, 5'b00011, 0, 0, 1);
        expect_counts("R6", 0, 0, 0, 0, 0);
        // R12 frame during reply ignored
        my_addr = 5'd5; resp_info = 4'b0110;
        tick();
        send_frame(0, 5'd5, 5'b00010, 0, 0, 0);
        send_frame(0, 5'd5, 5'b10000, 0, 0, 1);
        expect_counts("R12", 1, 0, 0, 0, 1);
        chk("R12", "req_info from first frame", int'(req_info), 2);
        repeat (5) tick();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule